// File: doc/BRIEF.md
# Piecewise-Linear Gamma Curve Engine

This block maps each 12-bit colour component of a pixel stream through one shared tone curve. The curve is held as 64 line segments over the input range 0 to 4095. Each segment has a stored start value (its offset) and a stored slope with eight fractional bits. The segments are narrow near black and wide near white. Every component of every valid pixel is looked up and interpolated by its own arithmetic lane. A result comes out two clock cycles after its pixel goes in.

Coefficient words can be written one at a time by a host, or built by an on-block loader. The loader reads a full 4096-entry curve table through a synchronous read port and derives offset and slope for each segment in turn. Both paths fill a pending table. The table that pixels actually use is replaced from the pending one only on a frame-start strobe, so a frame never mixes two curves.

Top module: `gamma_pwl_engine`

## Requirements
- R1: After reset both the pending and the active table hold all zeros, so every valid pixel maps to 0 on all channels; `pix_valid_out`, `load_busy` and `lut_addr` are 0.
- R2: Each cycle with `pix_valid_in` high yields exactly one cycle with `pix_valid_out` high two clock edges later, in input order, back-to-back inputs included.
- R3: Segment layout: inputs 0..15 are segments 0..15 of width 1; inputs 16..511 are segments 16..35, four each of width 4, 8, 16, 32 and 64, in rising order; inputs 512..4095 are segments 36..63 of width 128.
- R4: For input x in a segment starting at s, the output is min(4095, offset + (((x − s) × slope) >> 8)).
- R5: A host write (`cfg_we` high) stores `cfg_data` into pending entry `cfg_idx`, with the slope taken from bits 27:16 and the offset from bits 11:0; bits 15:12 are ignored.
- R6: On a clock edge with `frame_start` high, the active table becomes a copy of the pending table as it stood before that edge. A write in that same cycle lands only in the pending table. Without the strobe, pending writes do not change outputs.
- R7: Channel c of `pix_in` and `pix_out` occupies bits 12c+11..12c. All channels use the same active table.
- R8: A `load_start` pulse while idle raises `load_busy` on the next cycle and walks segments 0..63. For each segment the loader reads the table at the segment's first and last input; `lut_data` returns the entry addressed by `lut_addr` one cycle earlier. It writes offset = value at the first input and slope = floor((last value − first value) × 256 / (last input − first input)) into the pending table.
- R9: A segment whose first and last inputs coincide, or whose last value is not above its first value, gets slope 0; a computed slope above 4095 is stored as 4095.
- R10: Loader results reach pixels only after a later `frame_start`; `lut_addr` is 0 whenever `load_busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Copies pending table to active table |
| cfg_we | input | 1 | Host coefficient write strobe |
| cfg_idx | input | 6 | Segment index of the host write |
| cfg_data | input | 28 | Packed coefficient word (slope 27:16, offset 11:0) |
| load_start | input | 1 | Starts the table loader |
| load_busy | output | 1 | Loader is walking the segments |
| lut_addr | output | 12 | Curve table read address |
| lut_data | input | 12 | Curve table entry, one cycle after its address |
| pix_valid_in | input | 1 | Input pixel valid |
| pix_in | input | 36 | Input pixel, three 12-bit channels |
| pix_valid_out | output | 1 | Output pixel valid |
| pix_out | output | 36 | Corrected pixel, three 12-bit channels |

## Verification
The hardest situation to reach is a coefficient write that lands in the same cycle as the frame-start strobe. It tells apart a swap that copies the pre-write pending table from one that picks up the new word. The bench drives both strobes on one edge, with a word that differs from the one already pending at index 0. It then probes input 0 before and after a second strobe. The loader's clamp and zero-slope paths are reached by feeding it a steep curve, a falling curve and a quadratic curve, and sweeping every input value after each load.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
    localparam int PIX_W       = 12;
    localparam int SEG_N       = 64;
    localparam int IDX_W       = $clog2(SEG_N);
    localparam int FRAC_W      = 8;
    localparam int SLOPE_W     = 12;
    localparam int DELTA_W     = 7;
    localparam int SH_W        = 3;
    localparam int FINE_N      = 16;   // unit-width segments at the bottom
    localparam int MID_END     = 36;   // first index of the widest sector
    localparam int WIDE_SH     = 7;    // log2 width of widest segments
    localparam int WIDE_BASE   = 32;   // index = WIDE_BASE + (x >> WIDE_SH)
    localparam int MID_MSB_MAX = 8;
    localparam int WORD_W      = 28;
    localparam int SLOPE_LSB   = 16;
    localparam logic [PIX_W-1:0] PIX_MAX = '1;

    typedef struct packed {
        logic [SLOPE_W-1:0] slope;
        logic [PIX_W-1:0]   offset;
    } coef_t;

    function automatic logic [SH_W-1:0] seg_shift(input logic [IDX_W-1:0] idx);
        logic [IDX_W-1:0] rel;
        rel = idx - IDX_W'(FINE_N);
        if (idx < IDX_W'(FINE_N))       return '0;
        else if (idx < IDX_W'(MID_END)) return SH_W'((rel >> 2) + IDX_W'(2));
        else                            return SH_W'(WIDE_SH);
    endfunction

    function automatic logic [PIX_W-1:0] seg_first(input logic [IDX_W-1:0] idx);
        logic [IDX_W-1:0] rel;
        rel = idx - IDX_W'(FINE_N);
        if (idx < IDX_W'(FINE_N))       return PIX_W'(idx);
        else if (idx < IDX_W'(MID_END)) return (PIX_W'(4) | PIX_W'(rel[1:0])) << seg_shift(idx);
        else                            return PIX_W'(idx - IDX_W'(WIDE_BASE)) << WIDE_SH;
    endfunction

    function automatic logic [PIX_W-1:0] seg_last(input logic [IDX_W-1:0] idx);
        return seg_first(idx) | ((PIX_W'(1) << seg_shift(idx)) - PIX_W'(1));
    endfunction
endpackage

// File: rtl/gamma_seg_decode.sv
module gamma_seg_decode
    import gamma_pkg::*;
(
    input  logic [PIX_W-1:0]   pix,
    output logic [IDX_W-1:0]   idx,
    output logic [DELTA_W-1:0] delta
);
    logic [3:0]      msb;
    logic [SH_W-1:0] sh;

    always_comb begin
        msb = '0;
        for (int b = 0; b < PIX_W; b++) begin
            if (pix[b]) msb = 4'(b);
        end
        if (pix < PIX_W'(FINE_N)) begin
            sh  = '0;
            idx = IDX_W'(pix[3:0]);
        end else if (msb <= 4'(MID_MSB_MAX)) begin
            sh  = SH_W'(msb - 4'd2);
            idx = IDX_W'(FINE_N) + IDX_W'({msb - 4'd4, 2'b00})
                + IDX_W'((pix >> sh) & PIX_W'(3));
        end else begin
            sh  = SH_W'(WIDE_SH);
            idx = IDX_W'(WIDE_BASE) + IDX_W'(pix >> WIDE_SH);
        end
        delta = DELTA_W'(pix & ((PIX_W'(1) << sh) - PIX_W'(1)));
    end
endmodule

// File: rtl/gamma_lane_math.sv
module gamma_lane_math
    import gamma_pkg::*;
(
    input  logic [DELTA_W-1:0] delta,
    input  coef_t              coef,
    output logic [PIX_W-1:0]   result
);
    localparam int PROD_W = DELTA_W + SLOPE_W;

    logic [PROD_W-1:0] prod;
    logic [PIX_W:0]    sum;

    always_comb begin
        prod   = PROD_W'(delta) * PROD_W'(coef.slope);
        sum    = {1'b0, coef.offset} + (PIX_W+1)'(prod >> FRAC_W);
        result = sum[PIX_W] ? PIX_MAX : sum[PIX_W-1:0];
    end
endmodule

// File: rtl/gamma_coef_bank.sv
module gamma_coef_bank
    import gamma_pkg::*;
#(
    parameter int CH = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  coef_t                     wr_coef,
    input  logic                      swap,
    input  logic [CH-1:0][IDX_W-1:0]  rd_idx,
    output coef_t [CH-1:0]            rd_coef
);
    typedef struct packed {
        coef_t [SEG_N-1:0] pend;
        coef_t [SEG_N-1:0] act;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (swap)  bank_d.act = bank_q.pend;
        if (wr_en) bank_d.pend[wr_idx] = wr_coef;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    for (genvar c = 0; c < CH; c++) begin : g_rd
        assign rd_coef[c] = bank_q.act[rd_idx[c]];
    end
endmodule

// File: rtl/gamma_coef_loader.sv
module gamma_coef_loader
    import gamma_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    output logic               busy,
    output logic [PIX_W-1:0]   lut_addr,
    input  logic [PIX_W-1:0]   lut_data,
    output logic               wr_en,
    output logic [IDX_W-1:0]   wr_idx,
    output coef_t              wr_coef
);
    localparam int QUO_W = PIX_W + FRAC_W;
    localparam int CNT_W = $clog2(QUO_W);

    typedef enum logic [2:0] {
        LD_IDLE, LD_ADDR_LO, LD_ADDR_HI, LD_FETCH, LD_DIV, LD_WRITE
    } ld_state_e;

    typedef struct packed {
        ld_state_e          st;
        logic [IDX_W-1:0]   seg;
        logic [PIX_W-1:0]   v0;
        logic [DELTA_W-1:0] rem;
        logic [DELTA_W-1:0] divisor;
        logic [QUO_W-1:0]   quo;
        logic [CNT_W-1:0]   cnt;
    } ld_t;

    ld_t ld_d, ld_q;
    logic [SH_W-1:0]    sh;
    logic [PIX_W-1:0]   lo, hi;
    logic [DELTA_W:0]   trial;

    always_comb begin
        ld_d     = ld_q;
        sh       = seg_shift(ld_q.seg);
        lo       = seg_first(ld_q.seg);
        hi       = seg_last(ld_q.seg);
        lut_addr = '0;
        wr_en    = 1'b0;
        wr_idx   = ld_q.seg;
        wr_coef  = '0;
        trial    = {ld_q.rem, ld_q.quo[QUO_W-1]};
        case (ld_q.st)
            LD_IDLE: begin
                if (start) begin
                    ld_d.seg = '0;
                    ld_d.st  = LD_ADDR_LO;
                end
            end
            LD_ADDR_LO: begin
                lut_addr = lo;
                ld_d.st  = LD_ADDR_HI;
            end
            LD_ADDR_HI: begin
                lut_addr = hi;
                ld_d.v0  = lut_data;
                ld_d.st  = LD_FETCH;
            end
            LD_FETCH: begin
                lut_addr = hi;
                if (sh == '0 || lut_data <= ld_q.v0) begin
                    ld_d.quo = '0;
                    ld_d.st  = LD_WRITE;
                end else begin
                    ld_d.quo     = {lut_data - ld_q.v0, FRAC_W'(0)};
                    ld_d.rem     = '0;
                    ld_d.divisor = DELTA_W'((1 << sh) - 1);
                    ld_d.cnt     = CNT_W'(QUO_W - 1);
                    ld_d.st      = LD_DIV;
                end
            end
            LD_DIV: begin
                if (trial >= {1'b0, ld_q.divisor}) begin
                    ld_d.rem = DELTA_W'(trial - {1'b0, ld_q.divisor});
                    ld_d.quo = {ld_q.quo[QUO_W-2:0], 1'b1};
                end else begin
                    ld_d.rem = trial[DELTA_W-1:0];
                    ld_d.quo = {ld_q.quo[QUO_W-2:0], 1'b0};
                end
                if (ld_q.cnt == '0) ld_d.st  = LD_WRITE;
                else                ld_d.cnt = ld_q.cnt - 1'b1;
            end
            LD_WRITE: begin
                wr_en          = 1'b1;
                wr_coef.offset = ld_q.v0;
                wr_coef.slope  = (ld_q.quo > QUO_W'(PIX_MAX)) ? '1 : ld_q.quo[SLOPE_W-1:0];
                if (ld_q.seg == IDX_W'(SEG_N - 1)) begin
                    ld_d.st = LD_IDLE;
                end else begin
                    ld_d.seg = ld_q.seg + 1'b1;
                    ld_d.st  = LD_ADDR_LO;
                end
            end
            default: ld_d.st = LD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ld_q <= '{st: LD_IDLE, default: '0};
        else        ld_q <= ld_d;
    end

    assign busy = (ld_q.st != LD_IDLE);
endmodule

// File: rtl/gamma_pwl_engine.sv
module gamma_pwl_engine
    import gamma_pkg::*;
#(
    parameter int CHANNELS = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      frame_start,
    input  logic                      cfg_we,
    input  logic [IDX_W-1:0]          cfg_idx,
    input  logic [WORD_W-1:0]         cfg_data,
    input  logic                      load_start,
    output logic                      load_busy,
    output logic [PIX_W-1:0]          lut_addr,
    input  logic [PIX_W-1:0]          lut_data,
    input  logic                      pix_valid_in,
    input  logic [CHANNELS*PIX_W-1:0] pix_in,
    output logic                      pix_valid_out,
    output logic [CHANNELS*PIX_W-1:0] pix_out
);
    typedef struct packed {
        logic                              vld;
        logic [CHANNELS-1:0][DELTA_W-1:0]  delta;
        coef_t [CHANNELS-1:0]              coef;
    } fetch_t;

    typedef struct packed {
        logic                              vld;
        logic [CHANNELS-1:0][PIX_W-1:0]    pix;
    } emit_t;

    typedef struct packed {
        fetch_t fetch;
        emit_t  emit;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [CHANNELS-1:0][IDX_W-1:0]   seg_idx;
    logic [CHANNELS-1:0][DELTA_W-1:0] seg_delta;
    coef_t [CHANNELS-1:0]             act_coef;
    logic [CHANNELS-1:0][PIX_W-1:0]   lane_out;

    logic             ld_wr_en;
    logic [IDX_W-1:0] ld_wr_idx;
    coef_t            ld_wr_coef;
    logic             bk_wr_en;
    logic [IDX_W-1:0] bk_wr_idx;
    coef_t            bk_wr_coef;

    gamma_coef_loader u_loader (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (load_start),
        .busy     (load_busy),
        .lut_addr (lut_addr),
        .lut_data (lut_data),
        .wr_en    (ld_wr_en),
        .wr_idx   (ld_wr_idx),
        .wr_coef  (ld_wr_coef)
    );

    // loader words take precedence over a host word in the same cycle
    always_comb begin
        bk_wr_en = ld_wr_en | cfg_we;
        if (ld_wr_en) begin
            bk_wr_idx  = ld_wr_idx;
            bk_wr_coef = ld_wr_coef;
        end else begin
            bk_wr_idx         = cfg_idx;
            bk_wr_coef.slope  = cfg_data[SLOPE_LSB +: SLOPE_W];
            bk_wr_coef.offset = cfg_data[PIX_W-1:0];
        end
    end

    gamma_coef_bank #(.CH(CHANNELS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bk_wr_en),
        .wr_idx  (bk_wr_idx),
        .wr_coef (bk_wr_coef),
        .swap    (frame_start),
        .rd_idx  (seg_idx),
        .rd_coef (act_coef)
    );

    for (genvar c = 0; c < CHANNELS; c++) begin : g_lane
        gamma_seg_decode u_dec (
            .pix   (pix_in[c*PIX_W +: PIX_W]),
            .idx   (seg_idx[c]),
            .delta (seg_delta[c])
        );
        gamma_lane_math u_math (
            .delta  (pipe_q.fetch.delta[c]),
            .coef   (pipe_q.fetch.coef[c]),
            .result (lane_out[c])
        );
    end

    always_comb begin
        pipe_d             = pipe_q;
        pipe_d.fetch.vld   = pix_valid_in;
        pipe_d.fetch.delta = seg_delta;
        pipe_d.fetch.coef  = act_coef;
        pipe_d.emit.vld    = pipe_q.fetch.vld;
        pipe_d.emit.pix    = lane_out;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign pix_valid_out = pipe_q.emit.vld;
    assign pix_out       = pipe_q.emit.pix;
endmodule

// File: rtl/gamma_pwl_engine_chk.sv
module gamma_pwl_engine_chk
    import gamma_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             pix_valid_in,
    input logic             pix_valid_out,
    input logic             load_start,
    input logic             load_busy,
    input logic [PIX_W-1:0] lut_addr
);
    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid_in |-> ##2 pix_valid_out);

    // R2
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid_in |-> ##2 !pix_valid_out);

    // R8
    busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_busy) |-> $past(load_start));

    // R10
    idle_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_busy |-> (lut_addr == '0));
endmodule

bind gamma_pwl_engine gamma_pwl_engine_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .pix_valid_in  (pix_valid_in),
    .pix_valid_out (pix_valid_out),
    .load_start    (load_start),
    .load_busy     (load_busy),
    .lut_addr      (lut_addr)
);

// File: tb/gamma_pwl_engine_tb_top.sv
module gamma_pwl_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 20;
    localparam int VEC_X [NVEC] = '{0, 7, 15, 16, 19, 20, 31, 32, 63, 64,
                                    127, 128, 255, 256, 511, 512, 513, 1000, 2047, 4095};

    logic        clk = 0;
    logic        rst_n = 0;
    logic        frame_start = 0;
    logic        cfg_we = 0;
    logic [5:0]  cfg_idx = '0;
    logic [27:0] cfg_data = '0;
    logic        load_start = 0;
    logic        load_busy;
    logic [11:0] lut_addr;
    logic [11:0] lut_data = '0;
    logic        pix_valid_in = 0;
    logic [35:0] pix_in = '0;
    logic        pix_valid_out;
    logic [35:0] pix_out;

    int n_run = 0;
    int n_fail = 0;
    int curve_mode = 0;
    int seg_lo [64];
    int seg_hi [64];
    int pend_s [64];
    int pend_o [64];
    int act_s  [64];
    int act_o  [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    gamma_pwl_engine dut_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .load_start(load_start), .load_busy(load_busy),
        .lut_addr(lut_addr), .lut_data(lut_data),
        .pix_valid_in(pix_valid_in), .pix_in(pix_in),
        .pix_valid_out(pix_valid_out), .pix_out(pix_out)
    );

    function automatic int curve(input int a);
        case (curve_mode)
            0:       return (a * a) >> 12;
            1:       return 4095 - a;
            default: return (a * 16 > 4095) ? 4095 : a * 16;
        endcase
    endfunction

    // synchronous curve table: one cycle from address to data (R8)
    always @(posedge clk) lut_data <= 12'(curve(int'(lut_addr)));

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic build_segments();
        int n = 0;
        int base = 16;
        for (int i = 0; i < 16; i++) begin seg_lo[n] = i; seg_hi[n] = i; n++; end
        for (int w = 4; w <= 64; w = w * 2) begin
            for (int j = 0; j < 4; j++) begin
                seg_lo[n] = base; seg_hi[n] = base + w - 1; base += w; n++;
            end
        end
        while (base < 4096) begin
            seg_lo[n] = base; seg_hi[n] = base + 127; base += 128; n++;
        end
    endtask

    function automatic logic [11:0] model_out(input int x);
        int v = 0;
        for (int i = 0; i < 64; i++) begin
            if (x >= seg_lo[i] && x <= seg_hi[i])
                v = act_o[i] + (((x - seg_lo[i]) * act_s[i]) >> 8);
        end
        if (v > 4095) v = 4095;
        return 12'(v);
    endfunction

    task automatic send_pix(input int r, input int g, input int b, input string req);
        logic [35:0] exp;
        exp = {model_out(b), model_out(g), model_out(r)};
        @(negedge clk);
        pix_valid_in = 1; pix_in = {12'(b), 12'(g), 12'(r)};
        @(negedge clk);
        pix_valid_in = 0;
        check(pix_valid_out == 1'b0, "R2", "valid after one edge", pix_valid_out, 0);
        @(negedge clk);
        check(pix_valid_out == 1'b1, "R2", "valid after two edges", pix_valid_out, 1);
        check(pix_out == exp, req, "pixel", pix_out, exp);
    endtask

    task automatic host_write(input int idx, input int s, input int o, input bit with_swap);
        @(negedge clk);
        cfg_we = 1; cfg_idx = 6'(idx);
        cfg_data = {12'(s), 4'hF, 12'(o)};
        frame_start = with_swap;
        @(negedge clk);
        cfg_we = 0; frame_start = 0;
        if (with_swap) for (int i = 0; i < 64; i++) begin act_s[i] = pend_s[i]; act_o[i] = pend_o[i]; end
        pend_s[idx] = s; pend_o[idx] = o;
    endtask

    task automatic pulse_frame();
        @(negedge clk); frame_start = 1;
        @(negedge clk); frame_start = 0;
        for (int i = 0; i < 64; i++) begin act_s[i] = pend_s[i]; act_o[i] = pend_o[i]; end
    endtask

    task automatic run_loader(input int mode);
        curve_mode = mode;
        @(negedge clk); load_start = 1;
        @(negedge clk); load_start = 0;
        check(load_busy == 1'b1, "R8", "busy after start", load_busy, 1);
        while (load_busy) @(negedge clk);
        check(lut_addr == 12'd0, "R10", "idle address", lut_addr, 0);
        for (int i = 0; i < 64; i++) begin
            int v0 = curve(seg_lo[i]);
            int v1 = curve(seg_hi[i]);
            int s = 0;
            if (seg_hi[i] != seg_lo[i] && v1 > v0) s = ((v1 - v0) * 256) / (seg_hi[i] - seg_lo[i]);
            if (s > 4095) s = 4095;
            pend_s[i] = s; pend_o[i] = v0;
        end
    endtask

    task automatic sweep(input string req);
        for (int x = 0; x < 4096; x++) send_pix(x, 4095 - x, (x * 7) & 4095, req);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog run did not finish actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        build_segments();
        for (int i = 0; i < 64; i++) begin pend_s[i] = 0; pend_o[i] = 0; act_s[i] = 0; act_o[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(pix_valid_out == 1'b0, "R1", "valid at reset", pix_valid_out, 0);
        check(load_busy == 1'b0, "R1", "busy at reset", load_busy, 0);
        check(lut_addr == 12'd0, "R1", "lut_addr at reset", lut_addr, 0);
        send_pix(100, 2000, 4095, "R1");

        // R5: host words with junk in bits 15:12; R6: not active yet
        for (int i = 0; i < 64; i++) host_write(i, (i * 37 + 5) & 4095, (i * 61) & 4095, 0);
        send_pix(600, 3000, 9, "R6");
        pulse_frame();

        // R3 R4 R5 R7: vector table
        for (int v = 0; v < NVEC; v++)
            send_pix(VEC_X[v], 4095 - VEC_X[v], VEC_X[v] ^ 12'h555, "R3/R4/R5/R7");

        // R6: write and swap on the same edge
        host_write(0, 0, 777, 1);
        send_pix(0, 0, 0, "R6");
        pulse_frame();
        send_pix(0, 0, 0, "R6");

        // R8 R10: loader, result held back until frame start
        run_loader(0);
        send_pix(0, 1, 4095, "R10");
        pulse_frame();
        sweep("R8");

        // R9: falling curve gives zero slopes
        run_loader(1);
        pulse_frame();
        sweep("R9");

        // R9: steep curve clamps slope
        run_loader(2);
        pulse_frame();
        sweep("R9");

        // R2: back-to-back stream
        begin
            logic [35:0] e0, e1, e2;
            e0 = {model_out(100), model_out(100), model_out(100)};
            e1 = {model_out(200), model_out(2500), model_out(17)};
            e2 = {model_out(3000), model_out(5), model_out(700)};
            @(negedge clk); pix_valid_in = 1; pix_in = {12'd100, 12'd100, 12'd100};
            @(negedge clk); pix_in = {12'd200, 12'd2500, 12'd17};
            @(negedge clk);
            check(pix_valid_out && pix_out == e0, "R2", "stream 0", pix_out, e0);
            pix_in = {12'd3000, 12'd5, 12'd700};
            @(negedge clk); pix_valid_in = 0;
            check(pix_valid_out && pix_out == e1, "R2", "stream 1", pix_out, e1);
            @(negedge clk);
            check(pix_valid_out && pix_out == e2, "R2", "stream 2", pix_out, e2);
            @(negedge clk);
            check(pix_valid_out == 1'b0, "R2", "stream end", pix_valid_out, 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule